// File: doc/BRIEF.md
# CAN Controller Sleep and Wake Manager

This block governs the low-power sleep state of one CAN controller. Software asks for sleep by writing a one to a sleep-mode bit. The request is taken only when the bus has been quiet long enough and no interrupt is waiting. Otherwise the controller wakes again at once. While asleep, the controller wakes when the sampled bus shows a dominant bit at a bit-time strobe, or when software writes a zero to the sleep-mode bit. Every wake-up raises a sticky wake flag if the wake-interrupt enable is set. Software clears that flag with a write-one-to-clear strobe.

A wake-up caused by the bus leaves the receiver fenced off. The receive-allowed qualifier stays low until the bus has shown a run of recessive bits long enough to count as bus-free (11 by default). This keeps the controller from receiving the frame whose start woke it up. A wake-up by software does not fence the receiver. The sleep-mode bit that software reads back follows the sleep state, so the hardware clears it on any wake-up.

Top module: `canbus_doze_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, the block is awake. `sleep_bit` and `wake_flag` read 0 and `rx_allowed` reads 1.
- R2: A write of 1 (`sleep_wr`=1, `sleep_wr_val`=1) while awake puts the block to sleep at that edge. This needs `irq_pending`=0 and a bus that is free. Bus-free means the last IDLE_BITS strobed samples were recessive (`rx_bit`=1), with no dominant sample since reset. While asleep, `asleep`=1, `sleep_bit`=1 and `rx_allowed`=0.
- R3: A write of 1 while awake with `irq_pending`=1 leaves the block awake. It counts as a wake-up for the wake flag.
- R4: A write of 1 while awake with a bus that is not free leaves the block awake. It counts as a wake-up for the wake flag.
- R5: While asleep, a strobed dominant sample (`bit_tick`=1, `rx_bit`=0) wakes the block at that edge, and `sleep_bit` then reads 0.
- R6: While asleep, a write of 0 (`sleep_wr`=1, `sleep_wr_val`=0) wakes the block at that edge with `rx_allowed`=1.
- R7: A wake-up sets `wake_flag` only if `wake_ie` is 1 in the same cycle. With `wake_ie`=0 the flag keeps its value.
- R8: `wake_flag` holds until a cycle with `flag_clr`=1. If a wake-up with `wake_ie`=1 happens in the same cycle, the set wins.
- R9: After a wake-up from the bus, `rx_allowed` stays 0. It rises at the edge where the IDLE_BITS-th consecutive strobed recessive sample is taken. A strobed dominant sample restarts the run.
- R10: While asleep, recessive strobes and further writes of 1 leave the block asleep.
- R11: `rx_bit` is looked at only when `bit_tick`=1. A dominant level without the strobe neither wakes the block nor breaks a recessive run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | Strobe marking one sampled bit time |
| rx_bit | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| sleep_wr | input | 1 | Software write strobe to the sleep-mode bit |
| sleep_wr_val | input | 1 | Value written to the sleep-mode bit |
| wake_ie | input | 1 | Wake-interrupt enable |
| irq_pending | input | 1 | Some other interrupt of the controller is pending |
| flag_clr | input | 1 | Write-one-to-clear strobe for the wake flag |
| asleep | output | 1 | Controller is in sleep |
| sleep_bit | output | 1 | Sleep-mode bit as software reads it |
| wake_flag | output | 1 | Sticky wake-up interrupt flag |
| rx_allowed | output | 1 | Reception qualifier for the protocol engine |

## Verification
Every output comes from a register. So each result is due at the first rising edge that samples the stimulus and is visible right after that edge. This includes the release of `rx_allowed` on the closing recessive strobe of a run. The bench applies each stimulus just after a falling edge and lets one rising edge pass. It compares all four outputs at the next falling edge against a requirement-level model that advances once per cycle. Directed sequences count recessive strobes to one short of the bus-free length and then across it, so that an off-by-one edge shows up.

// File: rtl/doze_pkg.sv
package doze_pkg;

    // Reason for a wake-up in the current cycle
    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_SOFT = 2'd1,   // software write, including a refused sleep request
        WK_BUS  = 2'd2    // dominant bit seen on the bus
    } wake_cause_e;

    typedef struct packed {
        logic asleep;
        logic rx_block;
    } doze_state_t;

endpackage

// File: rtl/doze_idle_cnt.sv
module doze_idle_cnt #(
    parameter int IDLE_BITS = 11,
    parameter int CNT_W     = $clog2(IDLE_BITS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic rx_bit,
    output logic bus_free,
    output logic free_next
);
    localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(IDLE_BITS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (bit_tick) begin
            if (!rx_bit) begin
                cnt_d = '0;
            end else if (cnt_q != IDLE_CNT) begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign bus_free  = (cnt_q == IDLE_CNT);
    assign free_next = (cnt_d == IDLE_CNT);

    // R9/R11: a strobed dominant bit restarts the recessive run
    p_run_restart_r9: assert property (@(posedge clk) disable iff (rst)
        bit_tick && !rx_bit |=> cnt_q == '0);

    // R11: without a strobe the run length is untouched
    p_no_tick_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(cnt_q));

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= IDLE_CNT);

endmodule

// File: rtl/doze_state.sv
module doze_state
    import doze_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_tick,
    input  logic        rx_bit,
    input  logic        sleep_wr,
    input  logic        sleep_wr_val,
    input  logic        irq_pending,
    input  logic        bus_free,
    input  logic        free_next,
    output logic        asleep,
    output logic        rx_block,
    output wake_cause_e wake_cause
);
    doze_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        wake_cause = WK_NONE;
        if (st_q.asleep) begin
            if (bit_tick && !rx_bit) begin
                st_d.asleep   = 1'b0;
                st_d.rx_block = 1'b1;
                wake_cause    = WK_BUS;
            end else if (sleep_wr && !sleep_wr_val) begin
                st_d.asleep = 1'b0;
                wake_cause  = WK_SOFT;
            end
        end else begin
            if (st_q.rx_block && free_next) begin
                st_d.rx_block = 1'b0;
            end
            if (sleep_wr && sleep_wr_val) begin
                if (irq_pending || !bus_free) begin
                    wake_cause = WK_SOFT;   // refused: immediate wake-up
                end else begin
                    st_d.asleep = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{asleep: 1'b0, rx_block: 1'b0};
        else     st_q <= st_d;
    end

    assign asleep   = st_q.asleep;
    assign rx_block = st_q.rx_block;

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        !asleep && sleep_wr && sleep_wr_val && bus_free && !irq_pending |=> asleep);

    p_refuse_irq_r3: assert property (@(posedge clk) disable iff (rst)
        !asleep && sleep_wr && sleep_wr_val && irq_pending |=> !asleep);

    p_refuse_busy_r4: assert property (@(posedge clk) disable iff (rst)
        !asleep && sleep_wr && sleep_wr_val && !bus_free |=> !asleep);

    p_bus_wake_r5: assert property (@(posedge clk) disable iff (rst)
        asleep && bit_tick && !rx_bit |=> !asleep && rx_block);

    p_soft_wake_r6: assert property (@(posedge clk) disable iff (rst)
        asleep && sleep_wr && !sleep_wr_val && !(bit_tick && !rx_bit) |=> !asleep && !rx_block);

    p_stay_asleep_r10: assert property (@(posedge clk) disable iff (rst)
        asleep && !(bit_tick && !rx_bit) && !(sleep_wr && !sleep_wr_val) |=> asleep);

endmodule

// File: rtl/doze_wake_flag.sv
module doze_wake_flag (
    input  logic clk,
    input  logic rst,
    input  logic wake_evt,
    input  logic wake_ie,
    input  logic flag_clr,
    output logic wake_flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (wake_evt && wake_ie) flag_d = 1'b1;
        else if (flag_clr)       flag_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    assign wake_flag = flag_q;

    p_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !wake_flag && !(wake_evt && wake_ie) |=> !wake_flag);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        wake_evt && wake_ie |=> wake_flag);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        wake_flag && !flag_clr |=> wake_flag);

endmodule

// File: rtl/canbus_doze_ctrl.sv
module canbus_doze_ctrl
    import doze_pkg::*;
#(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic rx_bit,
    input  logic sleep_wr,
    input  logic sleep_wr_val,
    input  logic wake_ie,
    input  logic irq_pending,
    input  logic flag_clr,
    output logic asleep,
    output logic sleep_bit,
    output logic wake_flag,
    output logic rx_allowed
);
    localparam int CNT_W = $clog2(IDLE_BITS + 1);

    logic        bus_free, free_next, rx_block;
    wake_cause_e wake_cause;

    doze_idle_cnt #(.IDLE_BITS(IDLE_BITS), .CNT_W(CNT_W)) u_idle (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .rx_bit    (rx_bit),
        .bus_free  (bus_free),
        .free_next (free_next)
    );

    doze_state u_state (
        .clk          (clk),
        .rst          (rst),
        .bit_tick     (bit_tick),
        .rx_bit       (rx_bit),
        .sleep_wr     (sleep_wr),
        .sleep_wr_val (sleep_wr_val),
        .irq_pending  (irq_pending),
        .bus_free     (bus_free),
        .free_next    (free_next),
        .asleep       (asleep),
        .rx_block     (rx_block),
        .wake_cause   (wake_cause)
    );

    doze_wake_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .wake_evt  (wake_cause != WK_NONE),
        .wake_ie   (wake_ie),
        .flag_clr  (flag_clr),
        .wake_flag (wake_flag)
    );

    assign sleep_bit  = asleep;
    assign rx_allowed = !asleep && !rx_block;

    // R9: the receiver is never qualified while the controller sleeps
    p_rx_off_asleep_r9: assert property (@(posedge clk) disable iff (rst)
        asleep |-> !rx_allowed);

    // R1: state one cycle after reset
    p_reset_r1: assert property (@(posedge clk)
        rst |=> !asleep && !wake_flag && rx_allowed);

endmodule

// File: tb/canbus_doze_ctrl_test.sv
module canbus_doze_ctrl_test;
    localparam int IDLE = 11;

    logic clk = 1'b0;
    logic rst, bit_tick, rx_bit, sleep_wr, sleep_wr_val, wake_ie, irq_pending, flag_clr;
    logic asleep, sleep_bit, wake_flag, rx_allowed;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // bench model of the requirements
    bit m_asleep, m_flag, m_block;
    int m_run;

    always #10 clk = ~clk;   // 50 MHz

    canbus_doze_ctrl #(.IDLE_BITS(IDLE)) uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
        .sleep_wr(sleep_wr), .sleep_wr_val(sleep_wr_val), .wake_ie(wake_ie),
        .irq_pending(irq_pending), .flag_clr(flag_clr), .asleep(asleep),
        .sleep_bit(sleep_bit), .wake_flag(wake_flag), .rx_allowed(rx_allowed)
    );

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int next_run(int run, bit tk, bit rx);
        if (!tk) return run;
        if (!rx) return 0;
        return (run < IDLE) ? run + 1 : IDLE;
    endfunction

    // one cycle: drive after falling edge, compare at the next falling edge
    task automatic cyc(bit tk, bit rx, bit sw, bit swv, bit ie, bit irq, bit clr);
        int  run_n;
        bit  wake, bwake, asl_n;
        bit_tick = tk; rx_bit = rx; sleep_wr = sw; sleep_wr_val = swv;
        wake_ie = ie; irq_pending = irq; flag_clr = clr;
        run_n = next_run(m_run, tk, rx);
        wake = 0; bwake = 0; asl_n = m_asleep;
        if (m_asleep) begin
            if (tk && !rx)       begin asl_n = 0; wake = 1; bwake = 1; end
            else if (sw && !swv) begin asl_n = 0; wake = 1; end
        end else if (sw && swv) begin
            if (irq || m_run != IDLE) wake = 1;
            else asl_n = 1;
        end
        if (bwake) m_block = 1;
        else if (!m_asleep && m_block && run_n == IDLE) m_block = 0;
        if (wake && ie) m_flag = 1;
        else if (clr)   m_flag = 0;
        m_asleep = asl_n;
        m_run    = run_n;
        @(posedge clk);
        @(negedge clk);
        chk("R5 asleep",      asleep,     m_asleep);
        chk("R2 sleep_bit",   sleep_bit,  m_asleep);
        chk("R7 wake_flag",   wake_flag,  m_flag);
        chk("R9 rx_allowed",  rx_allowed, !m_asleep && !m_block);
    endtask

    task automatic idle_ticks(int n, bit ie);
        for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, ie, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; bit_tick = 0; rx_bit = 1; sleep_wr = 0; sleep_wr_val = 0;
        wake_ie = 0; irq_pending = 0; flag_clr = 0;
        m_asleep = 0; m_flag = 0; m_block = 0; m_run = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 asleep", asleep, 1'b0);
        chk("R1 sleep_bit", sleep_bit, 1'b0);
        chk("R1 wake_flag", wake_flag, 1'b0);
        chk("R1 rx_allowed", rx_allowed, 1'b1);

        // R4: bus not yet free, request refused, flag set
        idle_ticks(IDLE - 1, 1);
        cyc(0, 1, 1, 1, 1, 0, 0);
        chk("R4 refused", asleep, 1'b0);
        chk("R4 flag", wake_flag, 1'b1);
        cyc(0, 1, 0, 0, 1, 0, 1);
        chk("R8 cleared", wake_flag, 1'b0);

        // R11: dominant level without strobe does not break the run
        cyc(0, 0, 0, 0, 1, 0, 0);
        idle_ticks(1, 1);
        // R2: now bus-free, accepted
        cyc(0, 1, 1, 1, 1, 0, 0);
        chk("R2 asleep", asleep, 1'b1);
        chk("R2 sleep_bit", sleep_bit, 1'b1);
        chk("R2 rx_allowed", rx_allowed, 1'b0);

        // R10: recessive strobes and writes of 1 keep it asleep
        idle_ticks(5, 1);
        cyc(0, 1, 1, 1, 1, 0, 0);
        chk("R10 asleep", asleep, 1'b1);
        // R11: dominant without strobe does not wake
        cyc(0, 0, 0, 0, 1, 0, 0);
        chk("R11 asleep", asleep, 1'b1);

        // R5: strobed dominant wakes
        cyc(1, 0, 0, 0, 1, 0, 0);
        chk("R5 awake", asleep, 1'b0);
        chk("R5 sleep_bit", sleep_bit, 1'b0);
        chk("R7 flag set", wake_flag, 1'b1);
        chk("R9 blocked", rx_allowed, 1'b0);
        // R9: run broken one short, restart
        idle_ticks(IDLE - 1, 1);
        chk("R9 short run", rx_allowed, 1'b0);
        cyc(1, 0, 0, 0, 1, 0, 0);
        idle_ticks(IDLE - 1, 1);
        chk("R9 still short", rx_allowed, 1'b0);
        idle_ticks(1, 1);
        chk("R9 released", rx_allowed, 1'b1);

        // R8: sticky, then set beats clear (refused request with irq)
        cyc(0, 1, 0, 0, 1, 0, 0);
        chk("R8 sticky", wake_flag, 1'b1);
        cyc(0, 1, 0, 0, 1, 0, 1);
        chk("R8 clear", wake_flag, 1'b0);
        // R3: irq pending refuses sleep; set wins over clear
        cyc(0, 1, 1, 1, 1, 1, 1);
        chk("R3 refused", asleep, 1'b0);
        chk("R8 set wins", wake_flag, 1'b1);
        cyc(0, 1, 0, 0, 0, 0, 1);

        // R6 / R7: sleep, software wake with enable off
        cyc(0, 1, 1, 1, 0, 0, 0);
        chk("R6 slept", asleep, 1'b1);
        cyc(0, 1, 1, 0, 0, 0, 0);
        chk("R6 awake", asleep, 1'b0);
        chk("R6 rx_allowed", rx_allowed, 1'b1);
        chk("R7 gated", wake_flag, 1'b0);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            bit tk, rx, sw, swv, ie, irq, clr;
            tk  = ($urandom % 2) == 0;
            rx  = ($urandom % 16) != 0;
            sw  = ($urandom % 12) == 0;
            swv = ($urandom % 3) != 0;
            ie  = ($urandom % 4) != 0;
            irq = ($urandom % 6) == 0;
            clr = ($urandom % 8) == 0;
            cyc(tk, rx, sw, swv, ie, irq, clr);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule